// File: doc/BRIEF.md
# Tag-Ordered Transfer Command Queue

This block sits between a processor's command channel and a data transfer engine. Software offers transfer commands one per cycle. Each command names a local-store address, an effective address, a byte count, a 5-bit tag group, a direction and an optional ordering qualifier. Legal commands are held in a small pool of slots. The engine is offered one command at a time through a valid/ready pair. Completions come back by slot number.

Commands are not issued in strict arrival order. Each cycle the oldest command whose ordering constraints are satisfied is offered. A qualifier can hold a command back until earlier work in its own group is done. A standalone synchronising command holds back everything behind it. A 32-bit status word tells software which tag groups have no work left.

Top module: `dma_tagq`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_full`, `cmd_err` and `iss_valid` are 0 and every bit of `tag_status` is 1.
- R2: A legal command offered while `cmd_full` is 0 is stored in the same edge. `cmd_full` is 1 exactly while all 16 slots are occupied. A command offered while full is dropped and raises no error.
- R3: A command is rejected when any of the following holds: `cmd_size` is below 16 or above 16384; bits [3:0] of `cmd_lsa` or `cmd_ea` are nonzero on a transfer; `cmd_kind` is 3; `cmd_mod` is 3. A rejected command is not stored, and `cmd_err` is 1 in the cycle after the offer. Kind encoding: 0 = get, 1 = put, 2 = standalone barrier.
- R4: The issue port presents the stored fields of the chosen slot and that slot's number on `iss_id`. `iss_dir` is 1 for put (local store to effective address) and 0 for get. A slot leaves the waiting set on an edge where `iss_valid` and `iss_ready` are both 1.
- R5: Among eligible waiting commands, the oldest is offered. A command with no qualifier may overtake a blocked older command of another tag group.
- R6: A command with `cmd_mod` = 1 (fence) is not eligible while any older command of its own tag group is waiting or in flight.
- R7: A command with `cmd_mod` = 2 (barrier) obeys the fence rule. While it is still waiting, no younger command of its tag group is eligible.
- R8: A standalone barrier makes no younger command of any group eligible until every older command has completed. It then leaves the queue on the next edge without being offered.
- R9: `cpl_valid` with `cpl_id` naming an in-flight slot frees that slot. A completion naming a slot that is not in flight is ignored.
- R10: Bit t of `tag_status` is 1 exactly when no transfer of group t is waiting or in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_kind | input | 2 | 0 get, 1 put, 2 standalone barrier |
| cmd_mod | input | 2 | 0 none, 1 fence, 2 barrier |
| cmd_tag | input | 5 | Tag group |
| cmd_lsa | input | 32 | Local-store address |
| cmd_ea | input | 64 | Effective address |
| cmd_size | input | 15 | Byte count |
| cmd_full | output | 1 | All slots occupied |
| cmd_err | output | 1 | Previous cycle's offer was rejected |
| iss_valid | output | 1 | A command is offered to the engine |
| iss_ready | input | 1 | Engine takes the offered command |
| iss_id | output | 4 | Slot number of the offered command |
| iss_dir | output | 1 | 1 put, 0 get |
| iss_tag | output | 5 | Tag group of the offered command |
| iss_lsa | output | 32 | Local-store address |
| iss_ea | output | 64 | Effective address |
| iss_size | output | 15 | Byte count |
| cpl_valid | input | 1 | Engine reports a finished transfer |
| cpl_id | input | 4 | Slot number of the finished transfer |
| tag_status | output | 32 | Per-group idle flags |

## Verification
A completion and a new command of the same tag group can arrive on the same edge. The completion drains the group's last in-flight transfer, and the new command refills the group. The bench provokes this by holding `cpl_valid` and `cmd_valid` together for one edge. It then judges that the group's `tag_status` bit stays 0 and that the new command is offered in the next cycle. A second overlap is a completion that lifts a fence. The fenced command must appear on the issue port in the cycle right after that completion edge.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
    parameter int DQ_LSA_W = 32;
    parameter int DQ_EA_W  = 64;
    parameter int DQ_SZ_W  = 15;
    parameter int DQ_TAG_W = 5;

    typedef enum logic [1:0] {K_GET = 2'd0, K_PUT = 2'd1, K_SYNC = 2'd2, K_RSVD = 2'd3} kind_e;
    typedef enum logic [1:0] {M_NONE = 2'd0, M_FENCE = 2'd1, M_BAR = 2'd2, M_RSVD = 2'd3} mod_e;
    typedef enum logic [1:0] {S_FREE = 2'd0, S_WAIT = 2'd1, S_FLY = 2'd2} slot_e;

    typedef struct packed {
        kind_e                kind;
        mod_e                 md;
        logic [DQ_TAG_W-1:0]  tag;
        logic [DQ_LSA_W-1:0]  lsa;
        logic [DQ_EA_W-1:0]   ea;
        logic [DQ_SZ_W-1:0]   size;
    } entry_t;
endpackage

// File: rtl/dmaq_admit.sv
module dmaq_admit
    import dmaq_pkg::*;
#(
    parameter int MIN_SZ  = 16,
    parameter int MAX_SZ  = 16384,
    parameter int ALIGN_W = 4
) (
    input  logic [1:0]          kind,
    input  logic [1:0]          md,
    input  logic [ALIGN_W-1:0]  lsa_lo,
    input  logic [ALIGN_W-1:0]  ea_lo,
    input  logic [DQ_SZ_W-1:0]  size,
    output logic                legal
);
    logic is_xfer, size_ok, align_ok;

    always_comb begin
        is_xfer  = (kind == K_GET) || (kind == K_PUT);
        size_ok  = (size >= DQ_SZ_W'(MIN_SZ)) && (size <= DQ_SZ_W'(MAX_SZ));
        align_ok = (lsa_lo == '0) && (ea_lo == '0);
        if (kind == K_SYNC)
            legal = 1'b1;
        else
            legal = is_xfer && (md != M_RSVD) && size_ok && align_ok;
    end
endmodule

// File: rtl/dmaq_elig.sv
module dmaq_elig
    import dmaq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic [DEPTH-1:0]               occ,
    input  logic [DEPTH-1:0]               waiting,
    input  logic [DEPTH-1:0]               is_sync,
    input  logic [DEPTH-1:0]               has_fence,
    input  logic [DEPTH-1:0]               has_bar,
    input  logic [DEPTH-1:0][DQ_TAG_W-1:0] tags,
    input  logic [DEPTH-1:0][DEPTH-1:0]    older,
    output logic [DEPTH-1:0]               pick,
    output logic [DEPTH-1:0]               sync_done
);
    logic [DEPTH-1:0] elig;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DEPTH-1:0] same;
        logic blk_sync, blk_bar, blk_fence;

        always_comb begin
            for (int j = 0; j < DEPTH; j++)
                same[j] = occ[j] && !is_sync[j] && older[i][j] && (tags[j] == tags[i]);
            blk_sync  = |(older[i] & occ & is_sync);
            blk_bar   = |(same & waiting & has_bar);
            blk_fence = (has_fence[i] || has_bar[i]) && (|same);
            elig[i]   = waiting[i] && !is_sync[i] && !blk_sync && !blk_bar && !blk_fence;
            sync_done[i] = waiting[i] && is_sync[i] && !(|(older[i] & occ));
        end

        assign pick[i] = elig[i] && !(|(older[i] & elig));
    end
endmodule

// File: rtl/dmaq_tagmap.sv
module dmaq_tagmap
    import dmaq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int NTAG = 1 << DQ_TAG_W
) (
    input  logic [DEPTH-1:0]               live,
    input  logic [DEPTH-1:0][DQ_TAG_W-1:0] tags,
    output logic [NTAG-1:0]                idle
);
    for (genvar t = 0; t < NTAG; t++) begin : g_tag
        logic [DEPTH-1:0] hit;
        always_comb begin
            for (int i = 0; i < DEPTH; i++)
                hit[i] = live[i] && (tags[i] == DQ_TAG_W'(t));
        end
        assign idle[t] = ~(|hit);
    end
endmodule

// File: rtl/dma_tagq.sv
module dma_tagq
    import dmaq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int ID_W = $clog2(DEPTH),
    localparam int NTAG = 1 << DQ_TAG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_kind,
    input  logic [1:0]           cmd_mod,
    input  logic [DQ_TAG_W-1:0]  cmd_tag,
    input  logic [DQ_LSA_W-1:0]  cmd_lsa,
    input  logic [DQ_EA_W-1:0]   cmd_ea,
    input  logic [DQ_SZ_W-1:0]   cmd_size,
    output logic                 cmd_full,
    output logic                 cmd_err,
    output logic                 iss_valid,
    input  logic                 iss_ready,
    output logic [ID_W-1:0]      iss_id,
    output logic                 iss_dir,
    output logic [DQ_TAG_W-1:0]  iss_tag,
    output logic [DQ_LSA_W-1:0]  iss_lsa,
    output logic [DQ_EA_W-1:0]   iss_ea,
    output logic [DQ_SZ_W-1:0]   iss_size,
    input  logic                 cpl_valid,
    input  logic [ID_W-1:0]      cpl_id,
    output logic [NTAG-1:0]      tag_status
);
    typedef struct packed {
        entry_t [DEPTH-1:0]           ent;
        slot_e  [DEPTH-1:0]           st;
        logic   [DEPTH-1:0][DEPTH-1:0] older;
        logic                         err;
    } state_t;

    state_t q, d;

    logic                          legal;
    logic [DEPTH-1:0]              occ, waiting, is_sync, has_fence, has_bar, live;
    logic [DEPTH-1:0][DQ_TAG_W-1:0] tags;
    logic [DEPTH-1:0]              pick, sync_done;
    logic [ID_W-1:0]               free_id;
    logic                          any_free;

    dmaq_admit u_admit (
        .kind   (cmd_kind),
        .md     (cmd_mod),
        .lsa_lo (cmd_lsa[3:0]),
        .ea_lo  (cmd_ea[3:0]),
        .size   (cmd_size),
        .legal  (legal)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            occ[i]       = (q.st[i] != S_FREE);
            waiting[i]   = (q.st[i] == S_WAIT);
            is_sync[i]   = (q.ent[i].kind == K_SYNC);
            has_fence[i] = (q.ent[i].md == M_FENCE);
            has_bar[i]   = (q.ent[i].md == M_BAR);
            live[i]      = occ[i] && !is_sync[i];
            tags[i]      = q.ent[i].tag;
        end
    end

    dmaq_elig #(.DEPTH(DEPTH)) u_elig (
        .occ       (occ),
        .waiting   (waiting),
        .is_sync   (is_sync),
        .has_fence (has_fence),
        .has_bar   (has_bar),
        .tags      (tags),
        .older     (q.older),
        .pick      (pick),
        .sync_done (sync_done)
    );

    dmaq_tagmap #(.DEPTH(DEPTH)) u_tagmap (
        .live (live),
        .tags (tags),
        .idle (tag_status)
    );

    // lowest free slot and one-hot pick encoding
    always_comb begin
        free_id  = '0;
        any_free = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                free_id  = ID_W'(i);
                any_free = 1'b1;
            end
        end
        iss_id = '0;
        for (int i = 0; i < DEPTH; i++)
            if (pick[i]) iss_id = iss_id | ID_W'(i);
    end

    assign cmd_full  = !any_free;
    assign cmd_err   = q.err;
    assign iss_valid = |pick;
    assign iss_dir   = (q.ent[iss_id].kind == K_PUT);
    assign iss_tag   = q.ent[iss_id].tag;
    assign iss_lsa   = q.ent[iss_id].lsa;
    assign iss_ea    = q.ent[iss_id].ea;
    assign iss_size  = q.ent[iss_id].size;

    always_comb begin
        d     = q;
        d.err = cmd_valid && !legal;

        for (int i = 0; i < DEPTH; i++)
            if (sync_done[i]) d.st[i] = S_FREE;

        if (iss_valid && iss_ready)
            d.st[iss_id] = S_FLY;

        if (cpl_valid && (q.st[cpl_id] == S_FLY))
            d.st[cpl_id] = S_FREE;

        if (cmd_valid && legal && any_free) begin
            d.st[free_id]       = S_WAIT;
            d.ent[free_id].kind = kind_e'(cmd_kind);
            d.ent[free_id].md   = mod_e'(cmd_mod);
            d.ent[free_id].tag  = cmd_tag;
            d.ent[free_id].lsa  = cmd_lsa;
            d.ent[free_id].ea   = cmd_ea;
            d.ent[free_id].size = cmd_size;
            d.older[free_id]    = occ;
            for (int j = 0; j < DEPTH; j++)
                d.older[j][free_id] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.err <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                q.st[i]    <= S_FREE;
                q.ent[i]   <= '0;
                q.older[i] <= '0;
            end
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dmaq_sva.sv
module dmaq_sva
    import dmaq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int NTAG = 1 << DQ_TAG_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic                cmd_full,
    input logic                cmd_err,
    input logic                iss_valid,
    input logic                iss_ready,
    input logic [DQ_TAG_W-1:0] iss_tag,
    input logic [DQ_LSA_W-1:0] iss_lsa,
    input logic [DQ_EA_W-1:0]  iss_ea,
    input logic [DQ_SZ_W-1:0]  iss_size,
    input logic [NTAG-1:0]     tag_status
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!cmd_full && !cmd_err && !iss_valid && (&tag_status))); // R1

    AST_ISS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_lsa[3:0] == 4'h0 && iss_ea[3:0] == 4'h0
                       && iss_size >= DQ_SZ_W'(16) && iss_size <= DQ_SZ_W'(16384))); // R3

    AST_ERR_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_valid)); // R3

    AST_ISS_TAG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !tag_status[iss_tag]); // R10

    AST_FLIGHT_TAG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> !tag_status[$past(iss_tag)]); // R10
endmodule

bind dma_tagq dmaq_sva #(.DEPTH(DEPTH)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_full   (cmd_full),
    .cmd_err    (cmd_err),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .iss_tag    (iss_tag),
    .iss_lsa    (iss_lsa),
    .iss_ea     (iss_ea),
    .iss_size   (iss_size),
    .tag_status (tag_status)
);

// File: tb/sim_dma_tagq.sv
module sim_dma_tagq;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  kind;
        logic [4:0]  tag;
        logic [31:0] lsa;
        logic [63:0] ea;
        logic [14:0] size;
        logic        bad;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 5'd0,  32'h0000_0100, 64'h0000_0000_1000_0000, 15'd16,    1'b0},
        '{2'd1, 5'd31, 32'h0003_FFF0, 64'hFFFF_FFFF_FFFF_FFF0, 15'd16384, 1'b0},
        '{2'd0, 5'd12, 32'h0000_0200, 64'h0000_0000_0000_2000, 15'd15,    1'b1},
        '{2'd1, 5'd12, 32'h0000_0200, 64'h0000_0000_0000_2000, 15'd16385, 1'b1},
        '{2'd0, 5'd13, 32'h0000_0108, 64'h0000_0000_0000_3000, 15'd64,    1'b1},
        '{2'd1, 5'd14, 32'h0000_0300, 64'h0000_0000_0000_3004, 15'd64,    1'b1},
        '{2'd3, 5'd15, 32'h0000_0300, 64'h0000_0000_0000_3000, 15'd64,    1'b1},
        '{2'd1, 5'd20, 32'h0000_0080, 64'h0000_0000_0000_2000, 15'd128,   1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = '0;
    logic [1:0]  cmd_mod = '0;
    logic [4:0]  cmd_tag = '0;
    logic [31:0] cmd_lsa = '0;
    logic [63:0] cmd_ea = '0;
    logic [14:0] cmd_size = '0;
    logic        cmd_full, cmd_err, iss_valid, iss_dir;
    logic        iss_ready = 1'b0;
    logic [3:0]  iss_id;
    logic [4:0]  iss_tag;
    logic [31:0] iss_lsa;
    logic [63:0] iss_ea;
    logic [14:0] iss_size;
    logic        cpl_valid = 1'b0;
    logic [3:0]  cpl_id = '0;
    logic [31:0] tag_status;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_tagq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_mod(cmd_mod), .cmd_tag(cmd_tag), .cmd_lsa(cmd_lsa), .cmd_ea(cmd_ea),
        .cmd_size(cmd_size), .cmd_full(cmd_full), .cmd_err(cmd_err),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_id(iss_id),
        .iss_dir(iss_dir), .iss_tag(iss_tag), .iss_lsa(iss_lsa), .iss_ea(iss_ea),
        .iss_size(iss_size), .cpl_valid(cpl_valid), .cpl_id(cpl_id),
        .tag_status(tag_status)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic enq(input logic [1:0] k, input logic [1:0] m, input logic [4:0] t,
                       input logic [31:0] l, input logic [63:0] e, input logic [14:0] s);
        cmd_valid = 1'b1; cmd_kind = k; cmd_mod = m; cmd_tag = t;
        cmd_lsa = l; cmd_ea = e; cmd_size = s;
        step();
        cmd_valid = 1'b0;
        #1;
    endtask

    task automatic take(output logic [3:0] id);
        id = iss_id;
        iss_ready = 1'b1;
        step();
        iss_ready = 1'b0;
        #1;
    endtask

    task automatic done(input logic [3:0] id);
        cpl_valid = 1'b1; cpl_id = id;
        step();
        cpl_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] ida, idb, idc, idd;
        int n;
        repeat (3) step();
        // R1: reset state
        chk(!cmd_full && !cmd_err && !iss_valid && (&tag_status), "R1 reset idle",
            {cmd_full, cmd_err, iss_valid}, 0);
        rst_n = 1'b1;
        step();
        chk(!iss_valid && (&tag_status), "R1 after reset", tag_status, 32'hFFFF_FFFF);

        // table walk: R3 rejection, R4 field pass-through, R9/R10 retire
        for (int v = 0; v < NVEC; v++) begin
            enq(VECS[v].kind, 2'd0, VECS[v].tag, VECS[v].lsa, VECS[v].ea, VECS[v].size);
            chk(cmd_err == VECS[v].bad, "R3 err flag", cmd_err, VECS[v].bad);
            if (VECS[v].bad) begin
                chk(!iss_valid, "R3 rejected not stored", iss_valid, 0);
            end else begin
                chk(iss_valid && iss_lsa == VECS[v].lsa && iss_ea == VECS[v].ea &&
                    iss_size == VECS[v].size && iss_tag == VECS[v].tag &&
                    iss_dir == VECS[v].kind[0], "R4 issue fields", iss_ea, VECS[v].ea);
                chk(!tag_status[VECS[v].tag], "R10 tag busy", tag_status, 0);
                take(ida);
                chk(!tag_status[VECS[v].tag], "R10 in flight busy", tag_status, 0);
                done(ida);
                chk(&tag_status, "R9 completion frees", tag_status, 32'hFFFF_FFFF);
            end
        end

        // R5: oldest first in the same group
        enq(2'd0, 2'd0, 5'd1, 32'h10, 64'h100, 15'd32);
        enq(2'd0, 2'd0, 5'd1, 32'h20, 64'h200, 15'd32);
        chk(iss_lsa == 32'h10, "R5 oldest first", iss_lsa, 32'h10);
        take(ida); take(idb); done(ida); done(idb);

        // R6: fence waits for its group, other group overtakes
        enq(2'd0, 2'd0, 5'd3, 32'h100, 64'h1000, 15'd16);
        take(ida);
        enq(2'd1, 2'd1, 5'd3, 32'h110, 64'h1100, 15'd16);
        enq(2'd0, 2'd0, 5'd5, 32'h120, 64'h1200, 15'd16);
        chk(iss_valid && iss_tag == 5'd5, "R5 R6 other group overtakes fence", iss_tag, 5);
        take(idc);
        chk(!iss_valid, "R6 fence held", iss_valid, 0);
        done(ida);
        chk(iss_valid && iss_lsa == 32'h110, "R6 fence released after completion", iss_lsa, 32'h110);
        take(idb); done(idb); done(idc);

        // R7: barrier modifier holds itself and younger same-group commands
        enq(2'd0, 2'd0, 5'd7, 32'h200, 64'h2000, 15'd16);
        take(ida);
        enq(2'd0, 2'd2, 5'd7, 32'h210, 64'h2100, 15'd16);
        enq(2'd0, 2'd0, 5'd7, 32'h220, 64'h2200, 15'd16);
        enq(2'd1, 2'd0, 5'd9, 32'h230, 64'h2300, 15'd16);
        chk(iss_valid && iss_tag == 5'd9, "R7 other group passes", iss_tag, 9);
        take(idd);
        chk(!iss_valid, "R7 younger held behind barrier", iss_valid, 0);
        done(ida);
        chk(iss_valid && iss_lsa == 32'h210, "R7 barrier issues first", iss_lsa, 32'h210);
        take(idb);
        chk(iss_valid && iss_lsa == 32'h220, "R7 younger follows", iss_lsa, 32'h220);
        take(idc); done(idb); done(idc); done(idd);

        // R8: standalone barrier
        enq(2'd0, 2'd0, 5'd2, 32'h300, 64'h3000, 15'd16);
        take(ida);
        enq(2'd2, 2'd0, 5'd0, 32'h0, 64'h0, 15'd0);
        enq(2'd1, 2'd0, 5'd4, 32'h310, 64'h3100, 15'd16);
        chk(!iss_valid, "R8 all groups held", iss_valid, 0);
        done(ida);
        step();
        chk(iss_valid && iss_tag == 5'd4, "R8 released after drain", iss_tag, 4);
        take(ida); done(ida);
        chk(&tag_status, "R8 R10 idle", tag_status, 32'hFFFF_FFFF);

        // R9: completion of a waiting slot is ignored
        enq(2'd0, 2'd0, 5'd6, 32'h400, 64'h4000, 15'd16);
        ida = iss_id;
        done(ida);
        chk(iss_valid && iss_id == ida && !tag_status[6], "R9 stray completion ignored", iss_id, ida);
        take(ida);
        // same-cycle completion and enqueue in one group
        cpl_valid = 1'b1; cpl_id = ida;
        enq(2'd1, 2'd0, 5'd6, 32'h410, 64'h4100, 15'd16);
        cpl_valid = 1'b0;
        chk(!tag_status[6] && iss_valid && iss_lsa == 32'h410, "R10 refill same edge", tag_status, 0);
        take(ida); done(ida);

        // R2: full flag and drop while full
        for (int k = 0; k < 16; k++)
            enq(2'd0, 2'd0, 5'd10, 32'h1000 + 32'(k * 16), 64'h8000, 15'd16);
        chk(cmd_full, "R2 full at 16", cmd_full, 1);
        enq(2'd0, 2'd0, 5'd10, 32'h9990, 64'h8000, 15'd16);
        chk(!cmd_err, "R2 drop raises no error", cmd_err, 0);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            if (iss_valid) begin
                take(ida); done(ida); n++;
            end
        end
        chk(n == 16, "R2 only 16 stored", n, 16);
        chk(&tag_status && !cmd_full, "R2 R10 drained", tag_status, 32'hFFFF_FFFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule